// File: doc/BRIEF.md
# Redundant transfer selector

This block sits after a link receiver. It takes a stream of transfer words, each with an even parity bit and a code-error flag raised by the line decoder. When redundant mode is on, each transfer arrives twice in a row. The block checks both copies. It forwards the first copy if it is clean. If the first copy is bad, it forwards the second copy if that one is clean. If both copies are bad, it discards the transfer and raises an error event. When redundant mode is off, each word is a transfer of its own and is checked, then either forwarded or dropped. This mode carries twice the payload rate of redundant mode on the same link.

Each discarded transfer pulses a drop event. When the interrupt enable is high, the same discard also pulses an interrupt request. A counter records discards and stops at its maximum value. All outputs are registered and appear one cycle after the word that decides them.

Top module: `redundant_xfer_sel`

## Requirements
- R1: After reset, out_valid, drop_evt and err_irq are 0, err_count is 0, and the next accepted word is treated as a first copy.
- R2: A word is bad when in_code_err is 1, or when the XOR of all in_data bits and in_par is 1 (even parity over DATA_W+1 bits). Otherwise it is good.
- R3: In redundant mode, a good first copy appears on out_data with out_valid high in the cycle after it is accepted. Its second copy is consumed and never forwarded, whether it is good or bad.
- R4: In redundant mode, when the first copy is bad and the second copy is good, the second copy is forwarded in the cycle after the second copy is accepted.
- R5: In redundant mode, when both copies are bad, nothing is forwarded and drop_evt pulses for one cycle, in the cycle after the second copy is accepted.
- R6: With redund_en low, every accepted word is judged on its own. A good word is forwarded in the next cycle. A bad word produces a drop_evt pulse in the next cycle and no output.
- R7: err_irq pulses together with drop_evt only when irq_en was high in the cycle of the deciding word. Otherwise err_irq stays 0.
- R8: err_count increases by exactly one for each drop_evt pulse and holds at 2^CNT_W-1 once it reaches that value.
- R9: Cycles with in_valid low do not advance the pairing. At most one word is forwarded per pair.
- R10: A cycle with redund_en low clears the pairing, so the next accepted word in redundant mode is a first copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redund_en | input | 1 | 1: each transfer arrives twice; 0: single transfers |
| irq_en | input | 1 | Enables err_irq on discards |
| in_valid | input | 1 | A word is present this cycle |
| in_data | input | DATA_W | Transfer word |
| in_par | input | 1 | Even parity bit over in_data |
| in_code_err | input | 1 | Line decoder flagged this word |
| out_valid | output | 1 | out_data holds a forwarded transfer |
| out_data | output | DATA_W | Forwarded transfer word |
| drop_evt | output | 1 | One-cycle pulse per discarded transfer |
| err_irq | output | 1 | One-cycle interrupt pulse per discard while enabled |
| err_count | output | CNT_W | Saturating count of discards |

## Verification
A pairing phase that is out of step with the link makes the block treat second copies as first copies. The next clean pair then shows up as two forwarded words, or one word is missing, within one pair time. A wrong record of whether the first copy was clean shows up one cycle after the second copy: either a duplicate word on out_data, or a drop_evt pulse with no matching discard. Parity or counter faults show up at the first corrupted word: a wrong forward or drop decision, or an err_count that does not follow the drop pulses.

// File: rtl/rts_pkg.sv
package rts_pkg;
   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } phase_t;

   typedef struct packed {
      logic fwd;
      logic drop;
   } verdict_t;
endpackage

// File: rtl/rts_copy_check.sv
module rts_copy_check #(
   parameter int DATA_W  = 32,
   parameter int GROUP_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic              par,
   input  logic              code_err,
   output logic              bad
);
   localparam int NGRP  = (DATA_W + GROUP_W - 1) / GROUP_W;
   localparam int PAD_W = NGRP * GROUP_W;

   initial begin
      if (DATA_W < 1)  $error("rts_copy_check: DATA_W must be at least 1");
      if (GROUP_W < 1) $error("rts_copy_check: GROUP_W must be at least 1");
   end

   logic [PAD_W-1:0] padded;
   logic [NGRP-1:0]  grp_par;

   always_comb begin
      padded = '0;
      padded[DATA_W-1:0] = data;
   end

   // balanced parity tree: one XOR group per slice
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_par[g] = ^padded[g*GROUP_W +: GROUP_W];
   end

   assign bad = code_err | ((^grp_par) ^ par);
endmodule

// File: rtl/rts_pair_fsm.sv
module rts_pair_fsm
   import rts_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     redund_en,
   input  logic     beat_valid,
   input  logic     beat_bad,
   output verdict_t verdict
);
   phase_t phase_q;
   logic   first_ok_q;

   always_comb begin
      verdict = '0;
      if (!redund_en) begin
         verdict.fwd  = beat_valid & ~beat_bad;
         verdict.drop = beat_valid &  beat_bad;
      end else if (phase_q == PH_FIRST) begin
         verdict.fwd  = beat_valid & ~beat_bad;
      end else begin
         verdict.fwd  = beat_valid & ~first_ok_q & ~beat_bad;
         verdict.drop = beat_valid & ~first_ok_q &  beat_bad;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= PH_FIRST;
         first_ok_q <= 1'b0;
      end else if (!redund_en) begin
         phase_q    <= PH_FIRST;
         first_ok_q <= 1'b0;
      end else if (beat_valid) begin
         if (phase_q == PH_FIRST) begin
            phase_q    <= PH_SECOND;
            first_ok_q <= ~beat_bad;
         end else begin
            phase_q    <= PH_FIRST;
            first_ok_q <= 1'b0;
         end
      end
   end

   // R9: idle cycles leave the pairing untouched
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (redund_en && !beat_valid) |=> $stable(phase_q));

   // R3: a first copy never discards a transfer on its own
   a_r3_first_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (redund_en && phase_q == PH_FIRST) |-> !verdict.drop);
endmodule

// File: rtl/rts_sat_count.sv
module rts_sat_count #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   initial begin
      if (CNT_W < 1 || CNT_W > 32) $error("rts_sat_count: CNT_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                      cnt_q <= '0;
         else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   cnt_q <= '0;
         else if (inc) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count = cnt_q;

   // R8: the count only ever steps by one
   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || !SATURATE));

   // R8: a saturated count holds
   a_r8_hold_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/redundant_xfer_sel.sv
module redundant_xfer_sel
   import rts_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int GROUP_W = 8,
   parameter int CNT_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redund_en,
   input  logic              irq_en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_par,
   input  logic              in_code_err,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              drop_evt,
   output logic              err_irq,
   output logic [CNT_W-1:0]  err_count
);
   logic     beat_bad;
   verdict_t verdict;
   logic     valid_q, drop_q, irq_q;
   logic [DATA_W-1:0] data_q;

   rts_copy_check #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) i_check (
      .data(in_data), .par(in_par), .code_err(in_code_err), .bad(beat_bad)
   );

   rts_pair_fsm i_fsm (
      .clk(clk), .rst_n(rst_n), .redund_en(redund_en),
      .beat_valid(in_valid), .beat_bad(beat_bad), .verdict(verdict)
   );

   rts_sat_count #(.CNT_W(CNT_W), .SATURATE(1'b1)) i_cnt (
      .clk(clk), .rst_n(rst_n), .inc(verdict.drop), .count(err_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         drop_q  <= 1'b0;
         irq_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= verdict.fwd;
         drop_q  <= verdict.drop;
         irq_q   <= verdict.drop & irq_en;
         if (verdict.fwd) data_q <= in_data;
      end
   end

   assign out_valid = valid_q;
   assign out_data  = data_q;
   assign drop_evt  = drop_q;
   assign err_irq   = irq_q;

   // R5: a discard never coincides with a forwarded word
   a_r5_drop_no_out: assert property (@(posedge clk) disable iff (!rst_n)
      drop_evt |-> !out_valid);

   // R7: an interrupt only accompanies a discard
   a_r7_irq_needs_drop: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> drop_evt);

   // R8: each drop pulse is followed by a counter move unless saturated
   a_r8_count_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_evt && $past(err_count) != {CNT_W{1'b1}}) |-> err_count != $past(err_count));
endmodule

// File: tb/test_redundant_xfer_sel.sv
module test_redundant_xfer_sel;
   localparam int DW = 8;
   localparam int CW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic redund_en = 1'b0, irq_en = 1'b0, in_valid = 1'b0, in_par = 1'b0, in_code_err = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic out_valid, drop_evt, err_irq;
   logic [DW-1:0] out_data;
   logic [CW-1:0] err_count;

   always #4 clk = ~clk;

   redundant_xfer_sel #(.DATA_W(DW), .GROUP_W(3), .CNT_W(CW)) i_redundant_xfer_sel (
      .clk(clk), .rst_n(rst_n), .redund_en(redund_en), .irq_en(irq_en),
      .in_valid(in_valid), .in_data(in_data), .in_par(in_par), .in_code_err(in_code_err),
      .out_valid(out_valid), .out_data(out_data), .drop_evt(drop_evt),
      .err_irq(err_irq), .err_count(err_count)
   );

   int total = 0, bad = 0;
   int exp_drops = 0, got_drops = 0, exp_irqs = 0, got_irqs = 0;
   logic [DW-1:0] expq[$];
   string cur_tag = "R1";

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pop and compare away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (expq.size() == 0) chk(1'b0, {cur_tag, " unexpected output"}, int'(out_data), -1);
            else begin
               logic [DW-1:0] e;
               e = expq.pop_front();
               chk(out_data == e, {cur_tag, " forwarded word"}, int'(out_data), int'(e));
            end
         end
         if (drop_evt) got_drops++;
         if (err_irq)  got_irqs++;
      end
   end

   task automatic beat(input logic [DW-1:0] d, input bit pbad, input bit cerr);
      in_valid = 1'b1; in_data = d; in_par = (^d) ^ pbad; in_code_err = cerr;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0; in_code_err = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic note_drop();
      exp_drops++;
      if (irq_en) exp_irqs++;
   endtask

   // driver: a redundant pair; bad copies use parity (p) or code error (c)
   task automatic send_pair(input logic [DW-1:0] d1, input bit p1, input bit c1,
                            input logic [DW-1:0] d2, input bit p2, input bit c2);
      if (!(p1 | c1))      expq.push_back(d1);
      else if (!(p2 | c2)) expq.push_back(d2);
      else                 note_drop();
      beat(d1, p1, c1);
      beat(d2, p2, c2);
   endtask

   task automatic send_single(input logic [DW-1:0] d, input bit p, input bit c);
      if (!(p | c)) expq.push_back(d);
      else          note_drop();
      beat(d, p, c);
   endtask

   task automatic settle(input string tag);
      idle(3);
      chk(expq.size() == 0, {tag, " all expected words seen"}, expq.size(), 0);
      chk(got_drops == exp_drops, {tag, " drop pulses"}, got_drops, exp_drops);
      chk(got_irqs == exp_irqs, {tag, " irq pulses"}, got_irqs, exp_irqs);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(out_valid == 0 && drop_evt == 0 && err_irq == 0, "R1 outputs idle", out_valid, 0);
      chk(err_count == 0, "R1 count zero", err_count, 0);
      rst_n = 1'b1;
      redund_en = 1'b1;
      @(negedge clk);

      // R3: good first copy wins, second consumed (good or bad)
      cur_tag = "R3";
      send_pair(8'h11, 0, 0, 8'h22, 0, 0);
      send_pair(8'h33, 0, 0, 8'h44, 1, 0);
      send_pair(8'h55, 0, 0, 8'h66, 0, 1);
      settle("R3");

      // R4 and R2: first copy bad by parity or code error, second good
      cur_tag = "R4";
      send_pair(8'h77, 1, 0, 8'h78, 0, 0);
      send_pair(8'h99, 0, 1, 8'h9A, 0, 0);
      settle("R4");

      // R5 and R7: both bad, irq enabled
      cur_tag = "R5";
      irq_en = 1'b1;
      send_pair(8'hA0, 1, 0, 8'hA1, 0, 1);
      idle(1);
      chk(err_count == 1, "R8 count after one drop", err_count, 1);
      settle("R5");

      // R7: irq disabled, drop still counted
      cur_tag = "R7";
      irq_en = 1'b0;
      send_pair(8'hB0, 0, 1, 8'hB1, 1, 0);
      settle("R7");
      chk(err_count == 2, "R8 count after two drops", err_count, 2);

      // R9: idle gaps inside a pair
      cur_tag = "R9";
      beat(8'hC0, 0, 0); expq.push_back(8'hC0);
      idle(4);
      beat(8'hC1, 0, 0);
      idle(2);
      beat(8'hC2, 1, 0);
      idle(3);
      beat(8'hC3, 0, 0); expq.push_back(8'hC3);
      settle("R9");

      // R10: clearing redund_en realigns pairing
      cur_tag = "R10";
      beat(8'hD0, 1, 0);
      idle(1);
      redund_en = 1'b0;
      @(negedge clk);
      redund_en = 1'b1;
      send_pair(8'hD1, 0, 0, 8'hD2, 0, 0);
      settle("R10");

      // R6: single transfers, mixed good and bad, back to back
      cur_tag = "R6";
      redund_en = 1'b0;
      irq_en = 1'b1;
      send_single(8'hE0, 0, 0);
      send_single(8'hE1, 1, 0);
      send_single(8'hE2, 0, 0);
      send_single(8'hE3, 0, 1);
      send_single(8'hE4, 0, 0);
      settle("R6");
      chk(err_count == 4, "R8 count after single drops", err_count, 4);

      // R8 saturation at 7
      cur_tag = "R8";
      for (int i = 0; i < 6; i++) send_single(DW'(i), 1, 0);
      settle("R8");
      chk(err_count == 7, "R8 saturated count", err_count, 7);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule